// File: doc/BRIEF.md
# Hint-Aware Set Replacement Controller

This block holds the replacement state of one 16-way set and decides, on every request, whether the tag is already resident and which way a missing line displaces. Each request carries a tag and a priority hint: normal, evict-first or evict-last. For each way the block keeps a valid bit, a tag, a priority class, a 4-bit recency age and a pin timer. Hit, hit way, victim way and a flag for whether the victim held a valid line are all produced combinationally in the cycle of the request. The state update, whether refresh or install, happens at the next clock edge.

Victim choice is not a plain LRU over the set. The set is split into class subsets. A victim is the oldest line of the first subset that is eligible under a fixed priority chain. Evict-first lines are limited to 11 per set. Evict-last lines are limited by a selectable cap of 12 or 3. An evict-last line that gets no refresh while other requests keep arriving for a programmable number of request cycles is demoted to normal. The block has no data storage, no index decode and no fill timing. A surrounding cache instantiates one per set.

Top module: `hint_set_ctrl`

## Requirements
- R1: When `rst` is high at a clock edge, every way becomes invalid. A later request for any tag that was resident before reports a miss with `victimWasValid` low.
- R2: Hint encoding on `reqHint`: 2'b00 means normal, 2'b01 means evict-first, 2'b10 means evict-last, and 2'b11 is treated as normal. While `reqValid` is high, `hit` and `hitWay` report the way holding `reqTag` in the same cycle.
- R3: On a miss that hits no class cap, the lowest-numbered invalid way is the victim and `victimWasValid` is low.
- R4: Every hit or install makes the accessed way the most recent. A victim drawn from a subset is the least recently accessed line of that subset.
- R5: No more than 11 evict-first lines are ever resident. An evict-first miss with 11 already resident replaces the least recent evict-first line, even when invalid ways exist.
- R6: In a full set, a normal or evict-first miss displaces the least recent evict-first line whenever one exists, ahead of any older normal line.
- R7: A normal-hint hit on an evict-first line turns it into a normal line.
- R8: The evict-last cap is 12 when `pinCapSel` is 0 and 3 when it is 1. An evict-last miss at the cap replaces the least recent evict-last line, even when invalid ways exist.
- R9: While the evict-last count is below the cap, a miss in a full set never picks an evict-last line if a normal or evict-first line exists.
- R10: A normal-hint hit on an evict-last line leaves it evict-last.
- R11: An evict-last line that sees `PIN_TIMEOUT` consecutive requests that do not touch it becomes a normal line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, invalidates all ways |
| reqValid | input | 1 | Request strobe |
| reqTag | input | TAG_W | Tag of the request |
| reqHint | input | 2 | Priority hint (encoding in R2) |
| pinCapSel | input | 1 | Evict-last cap select: 0 gives 12, 1 gives 3 |
| hit | output | 1 | Request tag is resident |
| hitWay | output | 4 | Way holding the tag on a hit |
| victimWay | output | 4 | Way to be filled on a miss |
| victimWasValid | output | 1 | Miss displaces a valid line |

## Verification
The hardest condition to reach is demotion of pinned lines. It needs a set that is full, is at its evict-last cap, and then receives a long run of requests that avoid the pinned ways. The bench lowers `PIN_TIMEOUT` to 40. It fills the set with three pinned lines and thirteen normal lines, then hammers one normal way with hits. A normal miss then lands on a former pinned way instead of the oldest normal way. The single evict-first slot and the cap-over-invalid cases are reached by filling the set in a fixed order, so that every expected victim follows from the access order alone.

// File: rtl/hint_set_pkg.sv
package hint_set_pkg;
  localparam int NUM_WAYS = 16;
  localparam int WAY_W    = $clog2(NUM_WAYS);

  typedef enum logic [1:0] {
    CLS_NORMAL = 2'd0,
    CLS_FIRST  = 2'd1,
    CLS_LAST   = 2'd2
  } cls_e;

  // strobes from policy to state
  typedef struct packed {
    logic             touch;
    logic             fill;
    logic [WAY_W-1:0] way;
    cls_e             cls;
  } upd_t;
endpackage

// File: rtl/hint_set_state.sv
module hint_set_state
  import hint_set_pkg::*;
#(
  parameter int TAG_W       = 16,
  parameter int PIN_TIMEOUT = 100_000_000
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               reqValid,
  input  logic [TAG_W-1:0]                   reqTag,
  input  upd_t                               upd,
  output logic [NUM_WAYS-1:0]                validQ,
  output logic [NUM_WAYS-1:0][TAG_W-1:0]     tagQ,
  output cls_e [NUM_WAYS-1:0]                clsQ,
  output logic [NUM_WAYS-1:0][WAY_W-1:0]     ageQ
);
  localparam int TMR_W = $clog2(PIN_TIMEOUT + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(PIN_TIMEOUT - 1);

  logic [NUM_WAYS-1:0][TMR_W-1:0] tmrQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= '0;
      for (int i = 0; i < NUM_WAYS; i++) begin
        ageQ[i] <= WAY_W'(i);
        clsQ[i] <= CLS_NORMAL;
        tmrQ[i] <= '0;
      end
    end else begin
      // pin timers: only requests that miss this way advance it
      for (int i = 0; i < NUM_WAYS; i++) begin
        if (upd.touch && upd.way == WAY_W'(i)) begin
          tmrQ[i] <= '0;
        end else if (validQ[i] && clsQ[i] == CLS_LAST) begin
          if (reqValid) begin
            if (tmrQ[i] == TMR_LAST) begin
              clsQ[i] <= CLS_NORMAL;
              tmrQ[i] <= '0;
            end else begin
              tmrQ[i] <= tmrQ[i] + 1'b1;
            end
          end
        end else begin
          tmrQ[i] <= '0;
        end
      end
      if (upd.touch) begin
        for (int i = 0; i < NUM_WAYS; i++) begin
          if (upd.way == WAY_W'(i))
            ageQ[i] <= '0;
          else if (ageQ[i] < ageQ[upd.way])
            ageQ[i] <= ageQ[i] + 1'b1;
        end
        clsQ[upd.way] <= upd.cls;
        if (upd.fill) begin
          validQ[upd.way] <= 1'b1;
          tagQ[upd.way]   <= reqTag;
        end
      end
    end
  end

  AST_TOUCH_NEWEST: assert property (@(posedge clk) disable iff (rst)
    upd.touch |=> ageQ[$past(upd.way)] == '0) else $error("touched way not newest"); // R4
  AST_FILL_VALID: assert property (@(posedge clk) disable iff (rst)
    (upd.touch && upd.fill) |=> validQ[$past(upd.way)]) else $error("fill left way invalid"); // R3
endmodule

// File: rtl/hint_set_policy.sv
module hint_set_policy
  import hint_set_pkg::*;
#(
  parameter int TAG_W       = 16,
  parameter int FIRST_CAP   = 11,
  parameter int LAST_CAP_HI = 12,
  parameter int LAST_CAP_LO = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           reqValid,
  input  logic [TAG_W-1:0]               reqTag,
  input  logic [1:0]                     reqHint,
  input  logic                           pinCapSel,
  input  logic [NUM_WAYS-1:0]            validQ,
  input  logic [NUM_WAYS-1:0][TAG_W-1:0] tagQ,
  input  cls_e [NUM_WAYS-1:0]            clsQ,
  input  logic [NUM_WAYS-1:0][WAY_W-1:0] ageQ,
  output logic                           hit,
  output logic [WAY_W-1:0]               hitWay,
  output logic [WAY_W-1:0]               victimWay,
  output logic                           victimWasValid,
  output upd_t                           upd
);
  localparam int CNT_W = $clog2(NUM_WAYS + 1);
  localparam logic [CNT_W-1:0] CAP_FIRST = CNT_W'(FIRST_CAP);
  localparam logic [CNT_W-1:0] CAP_HI    = CNT_W'(LAST_CAP_HI);
  localparam logic [CNT_W-1:0] CAP_LO    = CNT_W'(LAST_CAP_LO);

  function automatic logic [WAY_W-1:0] pickOldest(
    input logic [NUM_WAYS-1:0] m,
    input logic [NUM_WAYS-1:0][WAY_W-1:0] ages);
    logic [WAY_W-1:0] best, bestAge;
    logic found;
    best = '0; bestAge = '0; found = 1'b0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (m[i] && (!found || ages[i] > bestAge)) begin
        best = WAY_W'(i); bestAge = ages[i]; found = 1'b1;
      end
    end
    return best;
  endfunction

  cls_e                  hintCls, hitCls;
  logic [NUM_WAYS-1:0]   matchVec, firstMask, lastMask, normMask, invMask;
  logic [CNT_W-1:0]      firstCnt, lastCnt, lastCap;
  logic                  hitAny;
  logic [WAY_W-1:0]      matchIdx, lowInv;

  always_comb begin
    case (reqHint)
      2'b01:   hintCls = CLS_FIRST;
      2'b10:   hintCls = CLS_LAST;
      default: hintCls = CLS_NORMAL;
    endcase
    firstCnt = '0; lastCnt = '0; matchIdx = '0; lowInv = '0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      matchVec[i]  = validQ[i] && tagQ[i] == reqTag;
      firstMask[i] = validQ[i] && clsQ[i] == CLS_FIRST;
      lastMask[i]  = validQ[i] && clsQ[i] == CLS_LAST;
      normMask[i]  = validQ[i] && clsQ[i] == CLS_NORMAL;
      invMask[i]   = !validQ[i];
      firstCnt     = firstCnt + CNT_W'(firstMask[i]);
      lastCnt      = lastCnt + CNT_W'(lastMask[i]);
      if (matchVec[i]) matchIdx = WAY_W'(i);
    end
    for (int i = NUM_WAYS - 1; i >= 0; i--)
      if (invMask[i]) lowInv = WAY_W'(i);
    hitAny  = |matchVec;
    lastCap = pinCapSel ? CAP_LO : CAP_HI;
  end

  // victim priority chain
  always_comb begin
    if (hintCls == CLS_FIRST && firstCnt >= CAP_FIRST)
      victimWay = pickOldest(firstMask, ageQ);
    else if (hintCls == CLS_LAST && lastCnt >= lastCap && |lastMask)
      victimWay = pickOldest(lastMask, ageQ);
    else if (|invMask)
      victimWay = lowInv;
    else if (|firstMask)
      victimWay = pickOldest(firstMask, ageQ);
    else if (|normMask)
      victimWay = pickOldest(normMask, ageQ);
    else
      victimWay = pickOldest(validQ, ageQ);
  end

  // class after a hit
  always_comb begin
    hitCls = clsQ[matchIdx];
    if (hintCls == CLS_NORMAL && clsQ[matchIdx] == CLS_FIRST)
      hitCls = CLS_NORMAL;
    else if (hintCls == CLS_LAST && (clsQ[matchIdx] == CLS_LAST || lastCnt < lastCap))
      hitCls = CLS_LAST;
  end

  assign hit            = reqValid && hitAny;
  assign hitWay         = matchIdx;
  assign victimWasValid = reqValid && !hitAny && validQ[victimWay];
  assign upd.touch      = reqValid;
  assign upd.fill       = reqValid && !hitAny;
  assign upd.way        = hitAny ? matchIdx : victimWay;
  assign upd.cls        = hitAny ? hitCls : hintCls;

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(matchVec)) else $error("tag resident twice"); // R2
  AST_FIRST_LIMIT: assert property (@(posedge clk) disable iff (rst)
    $countones(firstMask) <= FIRST_CAP) else $error("evict-first over cap"); // R5
  AST_PIN_AT_CAP: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !hitAny && hintCls == CLS_LAST && lastCnt >= lastCap)
      |-> clsQ[victimWay] == CLS_LAST) else $error("pin cap victim not pinned"); // R8
  AST_INVALID_PICK: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !hitAny && hintCls == CLS_NORMAL && |invMask)
      |-> !validQ[victimWay]) else $error("valid way taken over invalid"); // R3
  AST_RECLASS: assert property (@(posedge clk) disable iff (rst)
    (hit && hintCls == CLS_NORMAL && clsQ[hitWay] == CLS_FIRST)
      |=> clsQ[$past(hitWay)] == CLS_NORMAL) else $error("evict-first not reclassified"); // R7
endmodule

// File: rtl/hint_set_ctrl.sv
module hint_set_ctrl
  import hint_set_pkg::*;
#(
  parameter int TAG_W       = 16,
  parameter int FIRST_CAP   = 11,
  parameter int LAST_CAP_HI = 12,
  parameter int LAST_CAP_LO = 3,
  parameter int PIN_TIMEOUT = 100_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  input  logic [TAG_W-1:0] reqTag,
  input  logic [1:0]       reqHint,
  input  logic             pinCapSel,
  output logic             hit,
  output logic [3:0]       hitWay,
  output logic [3:0]       victimWay,
  output logic             victimWasValid
);
  upd_t                           upd;
  logic [NUM_WAYS-1:0]            validQ;
  logic [NUM_WAYS-1:0][TAG_W-1:0] tagQ;
  cls_e [NUM_WAYS-1:0]            clsQ;
  logic [NUM_WAYS-1:0][WAY_W-1:0] ageQ;

  hint_set_state #(.TAG_W(TAG_W), .PIN_TIMEOUT(PIN_TIMEOUT)) stateU (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqTag(reqTag), .upd(upd),
    .validQ(validQ), .tagQ(tagQ), .clsQ(clsQ), .ageQ(ageQ)
  );

  hint_set_policy #(.TAG_W(TAG_W), .FIRST_CAP(FIRST_CAP),
                    .LAST_CAP_HI(LAST_CAP_HI), .LAST_CAP_LO(LAST_CAP_LO)) policyU (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqTag(reqTag), .reqHint(reqHint),
    .pinCapSel(pinCapSel), .validQ(validQ), .tagQ(tagQ), .clsQ(clsQ), .ageQ(ageQ),
    .hit(hit), .hitWay(hitWay), .victimWay(victimWay),
    .victimWasValid(victimWasValid), .upd(upd)
  );
endmodule

// File: tb/hint_set_ctrl_test.sv
module hint_set_ctrl_test;
  localparam logic [1:0] H_NORM = 2'b00, H_FIRST = 2'b01, H_LAST = 2'b10;

  logic clk = 1'b0, rst = 1'b1, reqValid = 1'b0, pinCapSel = 1'b0;
  logic [15:0] reqTag = '0;
  logic [1:0]  reqHint = '0;
  logic hit, victimWasValid;
  logic [3:0] hitWay, victimWay;
  logic sHit, sVv;
  logic [3:0] sHitWay, sVic;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  hint_set_ctrl #(.PIN_TIMEOUT(40)) uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqTag(reqTag), .reqHint(reqHint),
    .pinCapSel(pinCapSel), .hit(hit), .hitWay(hitWay), .victimWay(victimWay),
    .victimWasValid(victimWasValid)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic capSel);
    @(negedge clk);
    rst = 1'b1; reqValid = 1'b0; pinCapSel = capSel;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // one request cycle; outputs sampled mid-cycle
  task automatic access(input int tag, input logic [1:0] h);
    @(negedge clk);
    reqValid = 1'b1; reqTag = 16'(tag); reqHint = h;
    #1;
    sHit = hit; sHitWay = hitWay; sVic = victimWay; sVv = victimWasValid;
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  task automatic testReset();
    doReset(1'b0);
    check("R1 idle hit", int'(hit), 0);
    access(0, H_NORM);
    check("R1 miss after reset", int'(sHit), 0);
    check("R3 first victim", int'(sVic), 0);
    check("R1 victim invalid", int'(sVv), 0);
  endtask

  task automatic testLru();
    doReset(1'b0);
    for (int i = 0; i < 16; i++) begin
      access(100 + i, H_NORM);
      check("R3 fill order", int'(sVic), i);
    end
    access(105, H_NORM);
    check("R2 hit", int'(sHit), 1);
    check("R2 hit way", int'(sHitWay), 5);
    access(200, H_NORM);
    check("R4 oldest victim", int'(sVic), 0);
    check("R4 victim valid", int'(sVv), 1);
    access(201, H_NORM);
    check("R4 next oldest", int'(sVic), 1);
    access(203, 2'b11);
    check("R2 hint 11 as normal", int'(sVic), 2);
    doReset(1'b0);
    access(105, H_NORM);
    check("R1 old tag gone", int'(sHit), 0);
    check("R1 old tag victim invalid", int'(sVv), 0);
  endtask

  task automatic testFirstCap();
    doReset(1'b0);
    for (int i = 0; i < 11; i++) access(300 + i, H_FIRST);
    access(320, H_FIRST);
    check("R5 cap victim", int'(sVic), 0);
    check("R5 cap victim valid", int'(sVv), 1);
    access(321, H_NORM);
    check("R3 invalid after cap", int'(sVic), 11);
    check("R3 invalid flag", int'(sVv), 0);
  endtask

  task automatic testFirstSlot();
    doReset(1'b0);
    for (int i = 0; i < 15; i++) access(400 + i, H_NORM);
    access(450, H_FIRST);
    check("R3 slot fill", int'(sVic), 15);
    access(451, H_FIRST);
    check("R6 first contends slot", int'(sVic), 15);
    access(452, H_FIRST);
    check("R6 slot again", int'(sVic), 15);
    access(453, H_NORM);
    check("R6 normal takes first", int'(sVic), 15);
  endtask

  task automatic testReclass();
    doReset(1'b0);
    for (int i = 0; i < 15; i++) access(500 + i, H_NORM);
    access(550, H_FIRST);
    access(550, H_NORM);
    check("R2 hit on first", int'(sHit), 1);
    check("R2 hit way first", int'(sHitWay), 15);
    access(551, H_FIRST);
    check("R7 reclassified", int'(sVic), 0);
  endtask

  task automatic testPinLow();
    doReset(1'b1);
    for (int i = 0; i < 3; i++) access(600 + i, H_LAST);
    for (int i = 0; i < 13; i++) access(610 + i, H_NORM);
    access(600, H_NORM);
    check("R10 hit pinned", int'(sHitWay), 0);
    access(650, H_NORM);
    check("R9 pinned protected", int'(sVic), 3);
    access(651, H_LAST);
    check("R10 stays pinned", int'(sVic), 1);
    check("R8 cap3 victim valid", int'(sVv), 1);
  endtask

  task automatic testPinHigh();
    doReset(1'b0);
    for (int i = 0; i < 12; i++) access(700 + i, H_LAST);
    access(720, H_LAST);
    check("R8 cap12 victim", int'(sVic), 0);
    check("R8 cap12 over invalid", int'(sVv), 1);
  endtask

  task automatic testTimeout();
    doReset(1'b1);
    for (int i = 0; i < 3; i++) access(800 + i, H_LAST);
    for (int i = 0; i < 13; i++) access(810 + i, H_NORM);
    access(850, H_LAST);
    check("R8 cap3 oldest pinned", int'(sVic), 0);
    for (int i = 0; i < 40; i++) access(822, H_NORM);
    check("R11 hammer hits", int'(sHitWay), 15);
    access(851, H_NORM);
    check("R11 demoted victim", int'(sVic), 1);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testReset();
    testLru();
    testFirstCap();
    testFirstSlot();
    testReclass();
    testPinLow();
    testPinHigh();
    testTimeout();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule